// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a CPU-side byte request port to an external parallel bus. On that bus the low address byte and the data byte share one set of lines, a separate byte carries the upper address bits, and an address latch enable plus active-low read and write strobes frame each transfer. Every accepted request is classified as internal or external by comparing its address with the top of internal memory. External requests run an address phase, a strobe phase stretched by zero to three wait cycles, and then return read data. Internal requests only show their address and latch enable on the pins.

The wait-state count depends on the sector. Addresses whose high byte is at or above a programmable split value use the upper-sector setting, and all others use the lower-sector setting. The number of high address pins the block owns is programmable. When the low byte is not driven, an optional keeper holds the last driven value. While the block is disabled it releases every pin it owns and treats every address as internal.

Top module: `extbus_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, rsp_done, ale and ad_oe are 0, rd_n and wr_n are 1, and rsp_rdata is 0.
- R2: With cfg_en high, an address greater than INT_LAST (default 0x10FF) is external and any other address is internal. rsp_ext reports this classification in the rsp_done cycle.
- R3: An internal access with cfg_en high keeps busy high for exactly one cycle. In that cycle ale is 1, ad_oe is 1, ad_out carries address bits 7:0 and the masked high byte is on ah_out. rd_n and wr_n stay 1.
- R4: The first busy cycle of an external access is the address phase: ale 1, ad_oe 1, ad_out = address bits 7:0, both strobes high. ale is 0 in every later cycle of the access.
- R5: The strobe of an external access stays low for 1+W cycles, where W is the selected wait-state count (0..3). busy is therefore high for 2+W cycles, which is 1+W cycles more than an internal access.
- R6: If address bits 15:8 are greater than or equal to cfg_split, W comes from cfg_ws_hi. Otherwise W comes from cfg_ws_lo.
- R7: During the strobe of an external write, wr_n is 0, ad_oe is 1 and ad_out equals the write data.
- R8: During the strobe of an external read, rd_n is 0 and ad_oe is 0. rsp_rdata takes the value ad_in had in the last strobe cycle. Internal accesses and writes return 0.
- R9: rd_n and wr_n are never both 0, and neither is 0 while ale is 1 or while busy is 0.
- R10: With cfg_en high, ah_own bit i is 1 exactly when i < cfg_hi_bits (values above 8 act as 8). ah_out bits outside that mask are 0.
- R11: With cfg_en and cfg_keep_en high and ad_oe low, keep_on is 1 and ad_out holds the last value the block drove. With cfg_keep_en low, ad_out is 0 whenever ad_oe is 0.
- R12: With cfg_en low, ad_oe, ale, keep_on and ah_own are 0 and both strobes are 1. Every access completes after one busy cycle, with rsp_ext 0.
- R13: A request is taken at a clock edge where req_valid is 1 and busy is 0. busy is high from the next cycle through the final data cycle, and requests presented while busy are ignored. rsp_done is a one-cycle pulse in the cycle after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Enables the bus interface and its pin ownership |
| cfg_hi_bits | input | 4 | Number of high address pins owned (0..8) |
| cfg_keep_en | input | 1 | Enables the keeper on the low byte lines |
| cfg_split | input | 8 | High-byte boundary between the two sectors |
| cfg_ws_lo | input | 2 | Wait states for the lower sector |
| cfg_ws_hi | input | 2 | Wait states for the upper sector |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_ext | output | 1 | Completed access was external |
| rsp_rdata | output | 8 | Read data from an external read |
| ad_out | output | 8 | Multiplexed low address / data value |
| ad_oe | output | 1 | Drive enable for the low byte lines |
| ad_in | input | 8 | Value seen on the low byte lines |
| ah_out | output | 8 | High address byte, masked |
| ah_own | output | 8 | Per-pin ownership of the high address lines |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| keep_on | output | 1 | Keeper active on the low byte lines |

## Verification
The assertions assume that the configuration inputs change only while busy is 0, because pin gating follows the live cfg_en and cfg_keep_en. They make no assumption about ad_in or about request inputs held while busy. The stimulus therefore changes configuration only between accesses, drives request fields on falling edges, and deliberately keeps a conflicting request asserted during one access to show that it is ignored.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int WS_W   = 2;
    localparam int HB_W   = $clog2(HI_W + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [HI_W-1:0]   hi_t;
    typedef logic [WS_W-1:0]   ws_t;
    typedef logic [HB_W-1:0]   hbits_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_INT  = 2'd1,
        PH_ADDR = 2'd2,
        PH_STRB = 2'd3
    } phase_e;

    typedef struct packed {
        addr_t addr;
        byte_t wdata;
        logic  we;
        logic  ext;
        ws_t   ws;
    } xfer_t;

    // Ownership mask of the high address lines for a requested count.
    function automatic hi_t hi_mask(hbits_t n);
        hi_t m;
        for (int i = 0; i < HI_W; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction

    function automatic byte_t addr_lo(addr_t a);
        return a[BYTE_W-1:0];
    endfunction

    function automatic hi_t addr_hi(addr_t a);
        return a[ADDR_W-1:BYTE_W];
    endfunction
endpackage

// File: rtl/extbus_decode.sv
module extbus_decode
    import extbus_pkg::*;
#(
    parameter addr_t INT_LAST = 16'h10FF
) (
    input  logic  en,
    input  addr_t addr,
    input  hi_t   split,
    input  ws_t   ws_lo,
    input  ws_t   ws_hi,
    output logic  ext,
    output ws_t   ws
);
    logic upper;

    always_comb begin
        ext   = en && (addr > INT_LAST);
        upper = (addr_hi(addr) >= split);
        ws    = upper ? ws_hi : ws_lo;
    end
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
    import extbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   req_we,
    input  addr_t  req_addr,
    input  byte_t  req_wdata,
    input  logic   dec_ext,
    input  ws_t    dec_ws,
    input  byte_t  ad_in,
    output phase_e phase,
    output xfer_t  xfer,
    output logic   busy,
    output logic   rsp_done,
    output logic   rsp_ext,
    output byte_t  rsp_rdata
);
    ws_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            xfer      <= '0;
            cnt       <= '0;
            rsp_done  <= 1'b0;
            rsp_ext   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        xfer.addr  <= req_addr;
                        xfer.wdata <= req_wdata;
                        xfer.we    <= req_we;
                        xfer.ext   <= dec_ext;
                        xfer.ws    <= dec_ws;
                        phase      <= dec_ext ? PH_ADDR : PH_INT;
                    end
                end
                PH_INT: begin
                    phase     <= PH_IDLE;
                    rsp_done  <= 1'b1;
                    rsp_ext   <= xfer.ext;
                    rsp_rdata <= '0;
                end
                PH_ADDR: begin
                    phase <= PH_STRB;
                    cnt   <= xfer.ws;
                end
                PH_STRB: begin
                    if (cnt == '0) begin
                        phase     <= PH_IDLE;
                        rsp_done  <= 1'b1;
                        rsp_ext   <= xfer.ext;
                        rsp_rdata <= xfer.we ? '0 : ad_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase != PH_IDLE);

    // Count of strobe cycles already elapsed, compared against the latched setting.
    logic [WS_W:0] strb_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            strb_run <= '0;
        end else if (phase == PH_STRB) begin
            strb_run <= strb_run + 1'b1;
        end else begin
            strb_run <= '0;
        end
    end

    // R5
    strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STRB && cnt == '0) |-> (strb_run == {1'b0, xfer.ws}));

    // R13
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (!busy && $past(busy)));

    // R13
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(xfer.addr) && $stable(xfer.we)));

    // R4
    addr_before_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ADDR) |=> (phase == PH_STRB));
endmodule

// File: rtl/extbus_pins.sv
module extbus_pins
    import extbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   keep_en,
    input  hbits_t hi_bits,
    input  phase_e phase,
    input  addr_t  x_addr,
    input  byte_t  x_wdata,
    input  logic   x_we,
    output byte_t  ad_out,
    output logic   ad_oe,
    output hi_t    ah_out,
    output hi_t    ah_own,
    output logic   ale,
    output logic   rd_n,
    output logic   wr_n,
    output logic   keep_on
);
    byte_t keep_q;
    byte_t drive_val;
    logic  addr_ph;
    logic  strb_ph;
    hi_t   mask;

    always_comb begin
        addr_ph = (phase == PH_INT) || (phase == PH_ADDR);
        strb_ph = (phase == PH_STRB);
        mask    = en ? hi_mask(hi_bits) : '0;

        drive_val = addr_ph ? addr_lo(x_addr) : x_wdata;
        ad_oe     = en && (addr_ph || (strb_ph && x_we));
        if (ad_oe) begin
            ad_out = drive_val;
        end else if (en && keep_en) begin
            ad_out = keep_q;
        end else begin
            ad_out = '0;
        end
        keep_on = en && keep_en && !ad_oe;

        ale    = en && addr_ph;
        rd_n   = !(en && strb_ph && !x_we);
        wr_n   = !(en && strb_ph && x_we);
        ah_own = mask;
        ah_out = addr_hi(x_addr) & mask;
    end

    // Last value driven onto the low byte lines, replayed by the keeper.
    always_ff @(posedge clk) begin
        if (rst) begin
            keep_q <= '0;
        end else if (ad_oe) begin
            keep_q <= drive_val;
        end
    end

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R9
    ale_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n));

    // R11
    keeper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && keep_en && !ad_oe && $past(en && keep_en)) |-> (ad_out == $past(ad_out)));

    // R8
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);
endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
    import extbus_pkg::*;
#(
    parameter addr_t INT_LAST = 16'h10FF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_en,
    input  logic [3:0]  cfg_hi_bits,
    input  logic        cfg_keep_en,
    input  logic [7:0]  cfg_split,
    input  logic [1:0]  cfg_ws_lo,
    input  logic [1:0]  cfg_ws_hi,
    input  logic        req_valid,
    input  logic        req_we,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        busy,
    output logic        rsp_done,
    output logic        rsp_ext,
    output logic [7:0]  rsp_rdata,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    input  logic [7:0]  ad_in,
    output logic [7:0]  ah_out,
    output logic [7:0]  ah_own,
    output logic        ale,
    output logic        rd_n,
    output logic        wr_n,
    output logic        keep_on
);
    logic   dec_ext;
    ws_t    dec_ws;
    phase_e phase;
    xfer_t  xfer;

    extbus_decode #(.INT_LAST(INT_LAST)) u_decode (
        .en    (cfg_en),
        .addr  (req_addr),
        .split (cfg_split),
        .ws_lo (cfg_ws_lo),
        .ws_hi (cfg_ws_hi),
        .ext   (dec_ext),
        .ws    (dec_ws)
    );

    extbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dec_ext   (dec_ext),
        .dec_ws    (dec_ws),
        .ad_in     (ad_in),
        .phase     (phase),
        .xfer      (xfer),
        .busy      (busy),
        .rsp_done  (rsp_done),
        .rsp_ext   (rsp_ext),
        .rsp_rdata (rsp_rdata)
    );

    extbus_pins u_pins (
        .clk     (clk),
        .rst     (rst),
        .en      (cfg_en),
        .keep_en (cfg_keep_en),
        .hi_bits (cfg_hi_bits),
        .phase   (phase),
        .x_addr  (xfer.addr),
        .x_wdata (xfer.wdata),
        .x_we    (xfer.we),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ah_out  (ah_out),
        .ah_own  (ah_own),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .keep_on (keep_on)
    );

    // R12
    disabled_release_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |-> (!ad_oe && ah_own == '0 && !ale && rd_n && wr_n && !keep_on));

    // R9
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> busy);

    // R4
    ale_single_chk: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    // R2
    ext_only_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_ext) |-> $past(cfg_en));
endmodule

// File: tb/extbus_ctrl_bench.sv
`timescale 1ns/1ps
module extbus_ctrl_bench;
    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  rdv;
        logic        ext;
        logic [1:0]  ws;
    } vec_t;

    // split 0x80, lower sector 1 wait, upper sector 3 waits, internal top 0x10FF
    localparam vec_t VECS [0:7] = '{
        '{1'b0, 16'h0040, 8'h00, 8'h11, 1'b0, 2'd1},
        '{1'b1, 16'h10FF, 8'hA7, 8'h00, 1'b0, 2'd1},
        '{1'b0, 16'h1100, 8'h00, 8'hC9, 1'b1, 2'd1},
        '{1'b1, 16'h7FFF, 8'h3E, 8'h00, 1'b1, 2'd1},
        '{1'b0, 16'h8000, 8'h00, 8'h6B, 1'b1, 2'd3},
        '{1'b1, 16'hFFFF, 8'h5A, 8'h00, 1'b1, 2'd3},
        '{1'b0, 16'hC3A5, 8'h00, 8'h3C, 1'b1, 2'd3},
        '{1'b1, 16'h2468, 8'h96, 8'h00, 1'b1, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_en, cfg_keep_en;
    logic [3:0]  cfg_hi_bits;
    logic [7:0]  cfg_split;
    logic [1:0]  cfg_ws_lo, cfg_ws_hi;
    logic        req_valid, req_we;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        busy, rsp_done, rsp_ext;
    logic [7:0]  rsp_rdata, ad_out, ad_in, ah_out, ah_own;
    logic        ad_oe, ale, rd_n, wr_n, keep_on;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    extbus_ctrl u_extbus_ctrl (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_hi_bits(cfg_hi_bits),
        .cfg_keep_en(cfg_keep_en), .cfg_split(cfg_split), .cfg_ws_lo(cfg_ws_lo),
        .cfg_ws_hi(cfg_ws_hi), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rsp_done(rsp_done), .rsp_ext(rsp_ext), .rsp_rdata(rsp_rdata),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ah_out(ah_out),
        .ah_own(ah_own), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .keep_on(keep_on)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] own_mask(input logic [3:0] n);
        if (n >= 4'd8) return 8'hFF;
        return (8'h01 << n) - 8'h01;
    endfunction

    // One access, checked cycle by cycle at falling edges.
    task automatic run_access(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1; req_we = v.we; req_addr = v.addr; req_wdata = v.wdata;
        ad_in = ~v.rdv;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R13 busy first cycle", busy, 1);
        chk("R9 strobes idle in address cycle", {rd_n, wr_n}, 2'b11);
        if (cfg_en) begin
            chk("R3/R4 ale in address cycle", ale, 1);
            chk("R3/R4 ad_oe in address cycle", ad_oe, 1);
            chk("R3/R4 low address byte", ad_out, v.addr[7:0]);
            chk("R10 high address byte", ah_out, v.addr[15:8] & own_mask(cfg_hi_bits));
        end else begin
            chk("R12 no ale when disabled", ale, 0);
            chk("R12 no drive when disabled", ad_oe, 0);
            chk("R12 no high pins when disabled", ah_own, 0);
        end
        if (v.ext) begin
            for (int k = 0; k <= int'(v.ws); k++) begin
                @(negedge clk);
                chk("R5 busy during strobe", busy, 1);
                chk("R4 ale low after address", ale, 0);
                if (v.we) begin
                    chk("R7 write strobe", {rd_n, wr_n}, 2'b10);
                    chk("R7 write drive", ad_oe, 1);
                    chk("R7 write data on bus", ad_out, v.wdata);
                end else begin
                    chk("R8 read strobe", {rd_n, wr_n}, 2'b01);
                    chk("R8 bus released on read", ad_oe, 0);
                    chk("R11 keeper value during read", ad_out,
                        cfg_keep_en ? {24'h0, v.addr[7:0]} : 32'h0);
                    chk("R11 keep_on during read", keep_on, cfg_keep_en);
                end
                if (k == int'(v.ws)) ad_in = v.rdv;
            end
        end
        @(negedge clk);
        chk("R5 busy falls on time", busy, 0);
        chk("R13 done pulse", rsp_done, 1);
        chk("R2 ext classification", rsp_ext, v.ext);
        chk("R8 read data", rsp_rdata, (v.ext && !v.we) ? {24'h0, v.rdv} : 32'h0);
        @(negedge clk);
        chk("R13 done is one cycle", rsp_done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_en = 1'b1; cfg_keep_en = 1'b1; cfg_hi_bits = 4'd8;
        cfg_split = 8'h80; cfg_ws_lo = 2'd1; cfg_ws_hi = 2'd3;
        req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; ad_in = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", rsp_done, 0);
        chk("R1 reset ale/oe", {ale, ad_oe}, 2'b00);
        chk("R1 reset strobes", {rd_n, wr_n}, 2'b11);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset busy", busy, 0);
        chk("R1 after reset rdata", rsp_rdata, 0);

        foreach (VECS[i]) run_access(VECS[i]);

        // R11: keeper replays the last driven write value while idle
        run_access('{1'b1, 16'hFFFF, 8'h5A, 8'h00, 1'b1, 2'd3});
        chk("R11 keeper holds after write", ad_out, 8'h5A);
        chk("R11 keep_on idle", keep_on, 1);

        // R6: split moved so 0x8000 now falls in the lower sector
        cfg_split = 8'h90;
        run_access('{1'b0, 16'h8000, 8'h00, 8'hE1, 1'b1, 2'd1});
        cfg_ws_lo = 2'd0;
        run_access('{1'b1, 16'h1234, 8'h77, 8'h00, 1'b1, 2'd0});
        cfg_split = 8'h80; cfg_ws_lo = 2'd1;

        // R10: partial and oversize high-pin counts
        cfg_hi_bits = 4'd3;
        @(negedge clk);
        chk("R10 three owned pins", ah_own, 8'h07);
        run_access('{1'b0, 16'hFE20, 8'h00, 8'h44, 1'b1, 2'd3});
        cfg_hi_bits = 4'd12;
        @(negedge clk);
        chk("R10 count above eight", ah_own, 8'hFF);
        cfg_hi_bits = 4'd0;
        @(negedge clk);
        chk("R10 zero owned pins", ah_own, 8'h00);
        cfg_hi_bits = 4'd8;

        // R11: keeper off leaves the idle bus at zero
        cfg_keep_en = 1'b0;
        run_access('{1'b0, 16'h2201, 8'h00, 8'h9D, 1'b1, 2'd1});
        chk("R11 keeper off idle value", ad_out, 0);
        chk("R11 keeper off flag", keep_on, 0);
        cfg_keep_en = 1'b1;

        // R13: a request held during busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = 16'h9055; ad_in = 8'h0F;
        @(negedge clk);
        req_addr = 16'h0010;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R13 address kept during busy", ah_out, 8'h90);
            chk("R13 busy held", busy, 1);
            if (k == 3) req_valid = 1'b0;
        end
        @(negedge clk);
        chk("R13 done after held request", rsp_done, 1);
        chk("R13 ignored request not started", busy, 0);
        chk("R8 held read data", rsp_rdata, 8'h0F);

        // R12: disabled interface
        cfg_en = 1'b0;
        run_access('{1'b0, 16'h8000, 8'h00, 8'h12, 1'b0, 2'd3});
        chk("R12 keep_on disabled", keep_on, 0);
        chk("R12 strobes disabled", {rd_n, wr_n}, 2'b11);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule